// File: doc/BRIEF.md
# Single-Position Shift and Rotate Unit

This block is a purely combinational shifter placed behind the arithmetic unit of a small datapath. It takes a data word, one carry-in bit and a three-bit operation select. In the same instant it gives back the moved word and a carry-out bit. Every operation moves the word by exactly one place, or by none.

The most significant select bit sets the direction: 0 means left or pass-through, 1 means right. The two lower bits choose what fills the vacated end of the word. The choices are the bit that wrapped around, a zero, the sign bit, or the carry-in. A caller gets rotates, logical shifts, arithmetic shifts and shifts through the carry from one code. Results are valid within the same cycle, and the block holds no state.

Top module: `shrot_unit`

## Requirements
- R1: Select code 3'b000 returns the operand unchanged with carry-out 0.
- R2: Code 3'b001 rotates left by one place: result bit 0 takes operand bit W-1, and carry-out is 0.
- R3: Code 3'b010 shifts left arithmetically: result bit 0 is 0, and carry-out equals operand bit W-1.
- R4: Code 3'b011 shifts left through the carry: result bit 0 takes carry-in, and carry-out equals operand bit W-1.
- R5: Code 3'b100 rotates right by one place: result bit W-1 takes operand bit 0, and carry-out is 0.
- R6: Code 3'b101 shifts right logically: result bit W-1 is 0, and carry-out equals operand bit 0.
- R7: Code 3'b110 shifts right arithmetically: result bit W-1 repeats operand bit W-1, and carry-out equals operand bit 0.
- R8: Code 3'b111 shifts right through the carry: result bit W-1 takes carry-in, and carry-out equals operand bit 0.
- R9: For every left code (001 to 011), result bits W-1..1 equal operand bits W-2..0. For every right code, result bits W-2..0 equal operand bits W-1..1.
- R10: Carry-in has no effect on the result or on carry-out for any code other than 3'b011 and 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | W (8) | Operand word |
| cin_i | input | 1 | Carry-in bit |
| func_i | input | 3 | Operation select |
| res_o | output | W (8) | Shifted or rotated word |
| cout_o | output | 1 | Carry-out bit |

## Verification
The moved word and the carry-out appear in the same cycle. A faulty design can therefore get one right and the other wrong, for example a correct sign fill paired with a carry taken from the wrong end. The bench drives every code with every operand, under both carry-in values. It judges the word and the carry together against a model that works through integer arithmetic. Carry-in is toggled on the six codes that must ignore it, and both outputs must stay unchanged.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    OP_PASS = 3'b000,
    OP_ROL  = 3'b001,
    OP_ASL  = 3'b010,
    OP_RLC  = 3'b011,
    OP_ROR  = 3'b100,
    OP_LSR  = 3'b101,
    OP_ASR  = 3'b110,
    OP_RRC  = 3'b111
  } shrot_op_e;
endpackage

// File: rtl/shrot_left.sv
module shrot_left #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  logic [1:0]   fill_i,  // 00 pass, 01 wrap, 10 zero, 11 carry
  output logic [W-1:0] y_o,
  output logic         co_o
);
  logic fill_bit;

  always_comb begin
    unique case (fill_i)
      2'b01:   fill_bit = a_i[W-1];
      2'b10:   fill_bit = 1'b0;
      2'b11:   fill_bit = cin_i;
      default: fill_bit = a_i[0];
    endcase
  end

  assign y_o[0] = (fill_i == 2'b00) ? a_i[0] : fill_bit;

  genvar i;
  generate
    for (i = 1; i < W; i++) begin : g_bit
      assign y_o[i] = (fill_i == 2'b00) ? a_i[i] : a_i[i-1];
    end
  endgenerate

  assign co_o = fill_i[1] & a_i[W-1];
endmodule

// File: rtl/shrot_right.sv
module shrot_right #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  logic [1:0]   fill_i,  // 00 wrap, 01 zero, 10 sign, 11 carry
  output logic [W-1:0] y_o,
  output logic         co_o
);
  logic fill_bit;

  always_comb begin
    unique case (fill_i)
      2'b00:   fill_bit = a_i[0];
      2'b01:   fill_bit = 1'b0;
      2'b10:   fill_bit = a_i[W-1];
      default: fill_bit = cin_i;
    endcase
  end

  assign y_o[W-1] = fill_bit;

  genvar i;
  generate
    for (i = 0; i < W-1; i++) begin : g_bit
      assign y_o[i] = a_i[i+1];
    end
  endgenerate

  assign co_o = (fill_i != 2'b00) & a_i[0];
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      opnd_i,
  input  logic              cin_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [W-1:0]      res_o,
  output logic              cout_o
);
  localparam int DIR_BIT = FUNC_W - 1;

  logic [W-1:0] left_y, right_y;
  logic         left_co, right_co;

  shrot_left #(.W(W)) u_left (
    .a_i(opnd_i), .cin_i(cin_i), .fill_i(func_i[1:0]),
    .y_o(left_y), .co_o(left_co)
  );

  shrot_right #(.W(W)) u_right (
    .a_i(opnd_i), .cin_i(cin_i), .fill_i(func_i[1:0]),
    .y_o(right_y), .co_o(right_co)
  );

  assign res_o  = func_i[DIR_BIT] ? right_y  : left_y;
  assign cout_o = func_i[DIR_BIT] ? right_co : left_co;
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opnd_i,
  input logic         cin_i,
  input logic [2:0]   func_i,
  input logic [W-1:0] res_o,
  input logic         cout_o
);
  always_comb begin
    if (func_i == 3'b000)
      a_r1_pass: assert (res_o == opnd_i && !cout_o);
    if (func_i == 3'b001 || func_i == 3'b100)
      a_r2_r5_rotate_no_carry: assert (!cout_o);
    if (func_i == 3'b010)
      a_r3_asl_zero_fill: assert (!res_o[0] && cout_o == opnd_i[W-1]);
    if (func_i == 3'b011)
      a_r4_rlc_carry: assert (res_o[0] == cin_i && cout_o == opnd_i[W-1]);
    if (func_i == 3'b110)
      a_r7_sign_kept: assert (res_o[W-1] == opnd_i[W-1] && cout_o == opnd_i[0]);
    if (func_i == 3'b111)
      a_r8_rrc_carry: assert (res_o[W-1] == cin_i && cout_o == opnd_i[0]);
    if (func_i[2])
      a_r9_right_body: assert (res_o[W-2:0] == opnd_i[W-1:1]);
    if (!func_i[2] && func_i != 3'b000)
      a_r9_left_body: assert (res_o[W-1:1] == opnd_i[W-2:0]);
  end
endmodule

bind shrot_unit shrot_unit_chk #(.W(W)) u_chk (
  .opnd_i(opnd_i), .cin_i(cin_i), .func_i(func_i),
  .res_o(res_o), .cout_o(cout_o)
);

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] opnd;
  logic         cin;
  logic [2:0]   func;
  logic [W-1:0] res;
  logic         cout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  shrot_unit #(.W(W)) u0 (
    .opnd_i(opnd), .cin_i(cin), .func_i(func),
    .res_o(res), .cout_o(cout)
  );

  function automatic string req_of(int f);
    case (f)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; 6: return "R7"; default: return "R8";
    endcase
  endfunction

  // Integer-arithmetic model: returns {carry, word}
  function automatic logic [W:0] model(int f, int a, int c);
    int top = (a >> (W-1)) & 1;
    int low = a & 1;
    int full = 1 << W;
    int y = a;
    int co = 0;
    case (f)
      1: y = ((a * 2) % full) + top;
      2: begin y = (a * 2) % full; co = top; end
      3: begin y = ((a * 2) % full) + c; co = top; end
      4: y = (a / 2) + low * (full / 2);
      5: begin y = a / 2; co = low; end
      6: begin y = (a / 2) + top * (full / 2); co = low; end
      7: begin y = (a / 2) + c * (full / 2); co = low; end
      default: ;
    endcase
    return {co[0], y[W-1:0]};
  endfunction

  task automatic check(string req, logic [W:0] exp);
    checks++;
    if ({cout, res} !== exp) begin
      errors++;
      $display("FAIL %s func=%0d opnd=%h cin=%0d got cout=%0d res=%h exp cout=%0d res=%h",
               req, func, opnd, cin, cout, res, exp[W], exp[W-1:0]);
    end
  endtask

  initial begin
    opnd = '0; cin = 1'b0; func = 3'b000;
    @(posedge clk);
    @(negedge clk);
    check("R1 idle", '0);
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < (1 << W); a++) begin
        logic [W:0] base;
        @(posedge clk);
        func = f[2:0]; opnd = a[W-1:0]; cin = 1'b0;
        @(negedge clk);
        base = model(f, a, 0);
        check(req_of(f), base);
        check("R9", base);
        @(posedge clk);
        cin = 1'b1;
        @(negedge clk);
        if (f == 3 || f == 7) check(req_of(f), model(f, a, 1));
        else check("R10 carry-in ignored", base);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; errors++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule